// File: doc/BRIEF.md
# Centre-Window Green Brightness Regulator

This block sits on the raw pixel stream of a 320 by 240 colour-mosaic image sensor. It estimates scene brightness from the stream without storing any image. Only samples at green mosaic sites inside a fixed 128 by 128 square at the image centre are used. They are summed while the frame streams past.

When the last pixel of a frame arrives, the sum becomes a mean. The mean is compared with a programmable band. The illumination level sent to the LED driver then moves one step up when the image is too dark, one step down when it is too bright, and is held when the mean is inside the band. The level always stays between a programmable floor and ceiling.

Pixel position comes from two markers that travel with pixels. A line marker says a pixel is the first of its line. A frame marker says a pixel is the first of a frame. Lines may be shorter than 320 pixels: the column counter only advances on valid pixels.

Top module: `centre_glow_regulator`

## Requirements
- R1: After reset `led_level` equals the parameter `RST_LVL` (default 128) and `mean_out` is 0.
- R2: Only samples whose column is 96 to 223 and whose line is 56 to 183 (both inclusive, counted from 0) enter the sum.
- R3: Inside that window, only samples whose line plus column is even (green sites) enter the sum. The other samples have no effect on `mean_out`.
- R4: End of frame is a valid pixel at line 239, column 319. On the clock edge that takes that pixel, `mean_out` becomes the frame sum shifted right by 13. `mean_out` changes at no other time.
- R5: One clock after a `mean_out` update, if the mean is below `thr_lo`, `led_level` rises by 1.
- R6: One clock after a `mean_out` update, if the mean is above `thr_hi`, `led_level` falls by 1.
- R7: A mean with `thr_lo <= mean <= thr_hi` leaves `led_level` unchanged. This includes a mean equal to either bound.
- R8: A rise never goes above `lvl_ceil`, and a fall never goes below `lvl_floor`. A rise at the ceiling stays at the ceiling, and a fall at the floor stays at the floor.
- R9: `led_level` changes only in the cycle after an end of frame, so it holds for the whole of a frame.
- R10: A valid pixel with `frame_go` high is line 0, column 0. It discards any partial sum, so an unfinished frame leaves no trace.
- R11: A valid pixel with `line_go` high is column 0 of the next line. Each other valid pixel takes the next column, and cycles with `pix_vld` low do not advance the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 10 | Raw pixel value |
| pix_vld | input | 1 | Pixel valid |
| line_go | input | 1 | Current pixel starts a line (sampled with pix_vld) |
| frame_go | input | 1 | Current pixel starts a frame (sampled with pix_vld) |
| thr_lo | input | 10 | Lower brightness bound |
| thr_hi | input | 10 | Upper brightness bound |
| lvl_floor | input | 8 | Minimum illumination level |
| lvl_ceil | input | 8 | Maximum illumination level |
| led_level | output | 8 | Illumination level to the LED driver |
| mean_out | output | 10 | Mean green brightness of the last complete frame |

## Verification
The assertions assume three things about the inputs:
- `lvl_floor` never exceeds `lvl_ceil`.
- The threshold and limit inputs are steady while a level update is taken.
- The first pixel of a frame carries `frame_go` and lies outside the window.

The stimulus respects all three. It sets the thresholds and limits only between frames, except for one deliberate change. That change comes several hundred cycles before the final pixel, and it pins both bounds to the expected mean so that the band edge is tested exactly. Frames begin with both markers on the first pixel. Lines outside the window are cut short, and idle cycles are mixed in. This exercises position tracking without breaking these assumptions.

// File: rtl/glow_pkg.sv
package glow_pkg;
  localparam int PIX_W = 10;
  typedef logic [PIX_W-1:0] pix_t;
  typedef enum logic [1:0] {GLOW_HOLD, GLOW_RAISE, GLOW_LOWER} glow_dir_e;

  // Decide the adjustment direction for one frame mean
  function automatic glow_dir_e glow_judge(pix_t mean, pix_t lo, pix_t hi);
    if (mean < lo)      return GLOW_RAISE;
    else if (mean > hi) return GLOW_LOWER;
    else                return GLOW_HOLD;
  endfunction
endpackage

// File: rtl/glow_pos_tracker.sv
module glow_pos_tracker #(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  parameter int WIN   = 128,
  localparam int COL_W = $clog2(IMG_W + 1),
  localparam int ROW_W = $clog2(IMG_H + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_vld,
  input  logic line_go,
  input  logic frame_go,
  output logic acc_en,
  output logic eof_evt,
  output logic frm_evt
);
  localparam logic [COL_W-1:0] COL_LO  = COL_W'((IMG_W - WIN) / 2);
  localparam logic [COL_W-1:0] COL_HI  = COL_W'((IMG_W - WIN) / 2 + WIN - 1);
  localparam logic [ROW_W-1:0] ROW_LO  = ROW_W'((IMG_H - WIN) / 2);
  localparam logic [ROW_W-1:0] ROW_HI  = ROW_W'((IMG_H - WIN) / 2 + WIN - 1);
  localparam logic [COL_W-1:0] COL_END = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] ROW_END = ROW_W'(IMG_H - 1);

  logic [COL_W-1:0] col_q, col_now;
  logic [ROW_W-1:0] row_q, row_now;
  logic             in_win, green_site;

  always_comb begin
    col_now = (line_go || frame_go) ? '0 : col_q;
    if (frame_go)     row_now = '0;
    else if (line_go) row_now = row_q + 1'b1;
    else              row_now = row_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pix_vld) begin
      col_q <= col_now + 1'b1;
      row_q <= row_now;
    end
  end

  assign in_win     = (col_now >= COL_LO) && (col_now <= COL_HI) &&
                      (row_now >= ROW_LO) && (row_now <= ROW_HI);
  assign green_site = (col_now[0] == row_now[0]);
  assign acc_en     = pix_vld && in_win && green_site;
  assign eof_evt    = pix_vld && (col_now == COL_END) && (row_now == ROW_END);
  assign frm_evt    = pix_vld && frame_go;

  // R11
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !line_go && !frame_go) |=> (col_q == $past(col_q) + 1'b1));

  // R11
  col_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> ($stable(col_q) && $stable(row_q)));
endmodule

// File: rtl/glow_accum.sv
module glow_accum #(
  parameter int WIN = 128,
  localparam int SHIFT = $clog2(WIN * WIN / 2),
  localparam int SUM_W = glow_pkg::PIX_W + SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  glow_pkg::pix_t pix_in,
  input  logic          acc_en,
  input  logic          eof_evt,
  input  logic          frm_evt,
  output glow_pkg::pix_t mean_q,
  output logic          upd_q
);
  logic [SUM_W-1:0] sum_q, sum_next;

  function automatic glow_pkg::pix_t mean_of(logic [SUM_W-1:0] s);
    return s[SUM_W-1:SHIFT];
  endfunction

  always_comb begin
    sum_next = frm_evt ? '0 : sum_q;
    if (acc_en) sum_next = sum_next + SUM_W'(pix_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q  <= '0;
      mean_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= eof_evt;
      if (eof_evt) begin
        mean_q <= mean_of(sum_next);
        sum_q  <= '0;
      end else begin
        sum_q <= sum_next;
      end
    end
  end

  // R4
  mean_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eof_evt |=> $stable(mean_q));

  // R10
  sum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_evt && !acc_en && !eof_evt) |=> (sum_q == '0));

  // R2
  acc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !frm_evt && !eof_evt) |=> $stable(sum_q));
endmodule

// File: rtl/glow_level_ctl.sv
module glow_level_ctl #(
  parameter int LVL_W = 8,
  parameter logic [LVL_W-1:0] RST_LVL = LVL_W'(128)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  glow_pkg::pix_t   mean,
  input  glow_pkg::pix_t   thr_lo,
  input  glow_pkg::pix_t   thr_hi,
  input  logic [LVL_W-1:0] lvl_floor,
  input  logic [LVL_W-1:0] lvl_ceil,
  output logic [LVL_W-1:0] lvl_q
);
  import glow_pkg::*;

  glow_dir_e dir;

  function automatic logic [LVL_W-1:0] step_lvl(glow_dir_e d, logic [LVL_W-1:0] cur,
                                                logic [LVL_W-1:0] fl, logic [LVL_W-1:0] ce);
    case (d)
      GLOW_RAISE: return (cur >= ce) ? ce : cur + 1'b1;
      GLOW_LOWER: return (cur <= fl) ? fl : cur - 1'b1;
      default:    return cur;
    endcase
  endfunction

  assign dir = glow_judge(mean, thr_lo, thr_hi);

  always_ff @(posedge clk) begin
    if (!rst_n)   lvl_q <= RST_LVL;
    else if (upd) lvl_q <= step_lvl(dir, lvl_q, lvl_floor, lvl_ceil);
  end

  // R9
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(lvl_q));

  // R5
  lvl_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && dir == GLOW_RAISE && lvl_q < lvl_ceil) |=> (lvl_q == $past(lvl_q) + 1'b1));

  // R6
  lvl_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && dir == GLOW_LOWER && lvl_q > lvl_floor) |=> (lvl_q == $past(lvl_q) - 1'b1));

  // R8
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q >= lvl_floor && lvl_q <= lvl_ceil));
endmodule

// File: rtl/centre_glow_regulator.sv
module centre_glow_regulator #(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  parameter int WIN   = 128,
  parameter int LVL_W = 8,
  parameter logic [LVL_W-1:0] RST_LVL = LVL_W'(128)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [glow_pkg::PIX_W-1:0] pix_in,
  input  logic                       pix_vld,
  input  logic                       line_go,
  input  logic                       frame_go,
  input  logic [glow_pkg::PIX_W-1:0] thr_lo,
  input  logic [glow_pkg::PIX_W-1:0] thr_hi,
  input  logic [LVL_W-1:0]           lvl_floor,
  input  logic [LVL_W-1:0]           lvl_ceil,
  output logic [LVL_W-1:0]           led_level,
  output logic [glow_pkg::PIX_W-1:0] mean_out
);
  logic acc_en, eof_evt, frm_evt, upd;

  glow_pos_tracker #(.IMG_W(IMG_W), .IMG_H(IMG_H), .WIN(WIN)) u_pos (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .line_go(line_go),
    .frame_go(frame_go), .acc_en(acc_en), .eof_evt(eof_evt), .frm_evt(frm_evt)
  );

  glow_accum #(.WIN(WIN)) u_acc (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .acc_en(acc_en),
    .eof_evt(eof_evt), .frm_evt(frm_evt), .mean_q(mean_out), .upd_q(upd)
  );

  glow_level_ctl #(.LVL_W(LVL_W), .RST_LVL(RST_LVL)) u_lvl (
    .clk(clk), .rst_n(rst_n), .upd(upd), .mean(mean_out), .thr_lo(thr_lo),
    .thr_hi(thr_hi), .lvl_floor(lvl_floor), .lvl_ceil(lvl_ceil), .lvl_q(led_level)
  );

  // R4
  upd_follows_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_evt |=> upd);
endmodule

// File: tb/test_centre_glow_regulator.sv
module test_centre_glow_regulator;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] pix_in;
  logic       pix_vld, line_go, frame_go;
  logic [9:0] thr_lo, thr_hi;
  logic [7:0] lvl_floor, lvl_ceil;
  logic [7:0] led_level;
  logic [9:0] mean_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_sum;
  int exp_mean;
  int exp_lvl;

  always #10 clk = ~clk;

  centre_glow_regulator i_centre_glow_regulator (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_vld(pix_vld),
    .line_go(line_go), .frame_go(frame_go), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .lvl_floor(lvl_floor), .lvl_ceil(lvl_ceil), .led_level(led_level),
    .mean_out(mean_out)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // A sample counts when it sits in the central square and on an even diagonal
  function automatic bit counts(int r, int c);
    return (r > 55) && (r < 184) && (c > 95) && (c < 224) && (((r + c) % 2) == 0);
  endfunction

  function automatic int model_lvl(int lvl, int m, int lo, int hi, int fl, int ce);
    if (m < lo) return (lvl + 1 > ce) ? ce : lvl + 1;
    if (m > hi) return (lvl - 1 < fl) ? fl : lvl - 1;
    return lvl;
  endfunction

  task automatic idle();
    @(negedge clk);
    pix_vld = 1'b0; line_go = 1'b0; frame_go = 1'b0; pix_in = 10'($urandom);
  endtask

  task automatic put_px(int r, int c, int v);
    @(negedge clk);
    pix_vld  = 1'b1;
    frame_go = (r == 0 && c == 0);
    line_go  = (c == 0);
    pix_in   = 10'(v);
    if (frame_go) exp_sum = 0;
    if (counts(r, c)) exp_sum += v;
  endtask

  // Stream rows 0..last_row; green window samples drawn from [g_lo, g_hi]
  task automatic run_frame(int g_lo, int g_hi, int last_row, bit exact, string tag);
    for (int r = 0; r <= last_row; r++) begin
      int ncol;
      if (r == 239) ncol = 320;
      else if (r >= 56 && r <= 183) ncol = 224;
      else ncol = 1 + int'($urandom % 3);
      if (r == 120 && c_ok()) begin
        // R9 and R4: nothing moves mid-frame
        check("R9 mid-frame level", int'(led_level), exp_lvl);
        check("R4 mid-frame mean", int'(mean_out), exp_mean);
      end
      if (r == 239 && exact) begin
        thr_lo = 10'(exp_sum >> 13);
        thr_hi = 10'(exp_sum >> 13);
      end
      for (int c = 0; c < ncol; c++) begin
        int v;
        if (counts(r, c)) v = g_lo + int'($urandom % (g_hi - g_lo + 1));
        else v = int'($urandom % 1024);
        put_px(r, c, v);
        if ((r < 56 || r > 183) && r != 239 && ($urandom % 4) == 0) idle();
      end
    end
    idle();
    if (last_row == 239) begin
      @(negedge clk);
      @(negedge clk);
      exp_lvl  = model_lvl(exp_lvl, exp_sum >> 13, thr_lo, thr_hi, lvl_floor, lvl_ceil);
      exp_mean = exp_sum >> 13;
      // R2 R3 R4
      check("R4 frame mean (R2 R3)", int'(mean_out), exp_mean);
      check(tag, int'(led_level), exp_lvl);
    end
  endtask

  function automatic bit c_ok();
    return 1'b1;
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = int'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; pix_vld = 1'b0; line_go = 1'b0; frame_go = 1'b0; pix_in = '0;
    thr_lo = 10'd300; thr_hi = 10'd600; lvl_floor = 8'd100; lvl_ceil = 8'd200;
    exp_sum = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset level", int'(led_level), 128);
    check("R1 reset mean", int'(mean_out), 0);
    exp_lvl = 128; exp_mean = 0;

    // R6: bright window -> step down
    run_frame(700, 1023, 239, 1'b0, "R6 bright lowers level");
    // R8: floor reached, bright again -> stays
    lvl_floor = 8'd127;
    run_frame(650, 1023, 239, 1'b0, "R8 floor holds");
    // R5: dark window -> step up (R11 via short lines and gaps)
    run_frame(0, 150, 239, 1'b0, "R5 dark raises level (R11)");
    // R7: mean exactly on both bounds -> hold
    run_frame(0, 1023, 239, 1'b1, "R7 band edge holds");
    // R10: abandoned partial frame of bright samples, then a fresh dark frame
    thr_lo = 10'd300; thr_hi = 10'd600; lvl_ceil = 8'd128;
    run_frame(900, 1023, 70, 1'b0, "R10 partial");
    check("R10 partial frame level", int'(led_level), exp_lvl);
    check("R10 partial frame mean", int'(mean_out), exp_mean);
    // R8: ceiling reached, dark -> stays; R10 partial sum discarded
    run_frame(0, 120, 239, 1'b0, "R8 ceiling holds (R10)");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule